// File: doc/BRIEF.md
# Trigger-Controlled Up-Counter

This block is an up-counting timer whose clock source, start, stop and clear can be handed to an external trigger. A selector picks the trigger from several lines: four internal trigger lines from sibling timers, a pulse made from every change of timer input 1, and the already-filtered timer inputs 1 and 2. A four-bit slave-mode code then decides what the selected trigger does. It can do nothing, clear the count on a rising edge, gate the count with its level, start the count on a rising edge, or supply the count steps itself, one per rising edge.

The counter wraps to zero after the auto-reload value and pulses an update flag. The auto-reload value in use is a shadow copy. It follows the input while the timer is stopped and is refreshed on every update event. A registered trigger output carries each rising edge of the selected trigger on to slave timers. An optional one-clock delay of this timer's own reaction keeps it in step with those slaves. The mode and select codes arrive split, with their top bits on separate ports, as they are stored in split register fields.

Top module: `tmr_slave_timer`

## Requirements
- R1: After reset the count, the update flag and the trigger output are all 0, and the run flag is clear.
- R2: In mode 0 (code 0) the count rises by one on each clock while the run flag is set. When the count equals the shadow reload value, the next step gives 0 and the update flag is 1 for that one cycle. The update flag is 1 only while the count shows 0.
- R3: In clear mode (code 4), a rising edge of the selected trigger sets the count to 0 and raises the update flag on the next clock, whether or not the run flag is set. Between edges, the counter counts as in mode 0.
- R4: In gated mode (code 5) the count steps only in cycles where the run flag is set and the selected trigger is high. It holds its value, without clearing, while the trigger is low.
- R5: In start mode (code 6), a rising edge of the selected trigger sets the run flag, and counting begins on the following clock. The count is not cleared. Later trigger activity has no effect, and the flag stays set until the enable input falls.
- R6: In external-step mode (code 7) the count steps once for each rising edge of the selected trigger while the run flag is set.
- R7: The trigger select code is {tsel_hi, tsel_lo}. Codes 0 to 3 pick itr[0] to itr[3], code 4 picks the change pulse of ti1, code 5 picks ti1f and code 6 picks ti2f.
- R8: A mode code {mode_hi, mode_lo} of 1 to 3 or 8 to 15, or a select code of 7 or above, makes the timer behave as in mode 0, with no trigger selected.
- R9: The trigger output is 1 for one cycle, one clock after each rising edge of the selected trigger. When msync is 1, every action of the trigger on this timer (edge or level) takes effect one clock later than it does with msync at 0.
- R10: The shadow reload value takes the arr input on every clock where the run flag is clear or an update event occurs. At all other times it holds.
- R11: A rising edge of cen sets the run flag and a falling edge clears it, each effective from the next clock. A falling edge takes priority over a trigger start in the same cycle.
- R12: The change pulse of ti1 is 1 for one cycle after each change of ti1, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_lo | input | 3 | Slave mode code, bits 2:0 |
| mode_hi | input | 1 | Slave mode code, bit 3 |
| tsel_lo | input | 3 | Trigger select code, bits 2:0 |
| tsel_hi | input | 2 | Trigger select code, bits 4:3 |
| msync | input | 1 | Delay this timer's reaction to the trigger by one clock |
| cen | input | 1 | Counter enable; its edges set and clear the run flag |
| arr | input | CNT_W | Auto-reload value |
| itr | input | N_ITR | Internal trigger lines |
| ti1 | input | 1 | Raw timer input 1, used by the change detector |
| ti1f | input | 1 | Filtered timer input 1 |
| ti2f | input | 1 | Filtered timer input 2 |
| cnt | output | CNT_W | Counter value |
| upd | output | 1 | One-cycle update event pulse |
| trgo | output | 1 | Trigger output for slave timers |

## Verification
A wrong run flag or shadow reload value stays hidden until the next count step. It then appears as a missed or extra increment, or as a wrap at the wrong count, one clock after the cause. A wrong registered trigger copy gives a missing or duplicated trigger output pulse on the next clock. It also moves the clear, the start or the external step by one cycle, so it shows on cnt within two clocks. The reference model is compared with cnt, upd and trgo after every clock edge, so any difference is reported in the cycle where it first becomes visible.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

  localparam int MODE_W = 4;
  localparam int TSEL_W = 5;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF    = 4'd0,
    SM_CLEAR  = 4'd4,
    SM_GATE   = 4'd5,
    SM_START  = 4'd6,
    SM_EXTCLK = 4'd7
  } smode_e;

  // Number of selectable sources for a given internal trigger count.
  function automatic int src_count(int n_itr);
    return n_itr + 3;
  endfunction

  function automatic logic tsel_ok(logic [TSEL_W-1:0] sel, int n_itr);
    return int'(sel) < src_count(n_itr);
  endfunction

  // Reserved mode codes, or a missing trigger, fall back to free running.
  function automatic smode_e mode_decode(logic [MODE_W-1:0] raw, logic sel_valid);
    smode_e m;
    m = SM_OFF;
    if (sel_valid) begin
      case (raw)
        4'd4: m = SM_CLEAR;
        4'd5: m = SM_GATE;
        4'd6: m = SM_START;
        4'd7: m = SM_EXTCLK;
        default: m = SM_OFF;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux
  import tmr_slave_pkg::*;
#(
  parameter int N_ITR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TSEL_W-1:0] tsel,
  input  logic [N_ITR-1:0]  itr,
  input  logic              ti1,
  input  logic              ti1f,
  input  logic              ti2f,
  output logic              trg,
  output logic              sel_valid
);

  localparam int SEL_ED  = N_ITR;
  localparam int SEL_T1F = N_ITR + 1;
  localparam int SEL_T2F = N_ITR + 2;

  logic ti1_q;
  logic ti1_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ti1_q <= 1'b0;
    else        ti1_q <= ti1;
  end

  assign ti1_chg   = ti1 ^ ti1_q;
  assign sel_valid = tsel_ok(tsel, N_ITR);

  always_comb begin
    trg = 1'b0;
    for (int i = 0; i < N_ITR; i++) begin
      if (tsel == TSEL_W'(i)) trg = itr[i];
    end
    if (tsel == TSEL_W'(SEL_ED))  trg = ti1_chg;
    if (tsel == TSEL_W'(SEL_T1F)) trg = ti1f;
    if (tsel == TSEL_W'(SEL_T2F)) trg = ti2f;
  end

  p_no_trig_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> !trg);

  p_chg_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == TSEL_W'(SEL_ED)) && (ti1 != ti1_q) |-> trg);

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slave_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  smode_e mode,
  input  logic   msync,
  input  logic   cen,
  input  logic   trg,
  output logic   run,
  output logic   tick,
  output logic   clr,
  output logic   trgo
);

  logic trg_q, ev_q, cen_q, run_q;
  logic ev_raw, ev_eff, lvl_eff;
  logic cen_rise, cen_fall, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q <= 1'b0;
      ev_q  <= 1'b0;
      cen_q <= 1'b0;
    end else begin
      trg_q <= trg;
      ev_q  <= ev_raw;
      cen_q <= cen;
    end
  end

  assign ev_raw   = trg & ~trg_q;
  assign ev_eff   = msync ? ev_q  : ev_raw;
  assign lvl_eff  = msync ? trg_q : trg;
  assign cen_rise = cen & ~cen_q;
  assign cen_fall = ~cen & cen_q;
  assign start    = (mode == SM_START) & ev_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= 1'b0;
    else if (cen_fall)          run_q <= 1'b0;
    else if (cen_rise || start) run_q <= 1'b1;
  end

  always_comb begin
    case (mode)
      SM_GATE:   tick = run_q & lvl_eff;
      SM_EXTCLK: tick = run_q & ev_eff;
      default:   tick = run_q;
    endcase
  end

  assign clr  = (mode == SM_CLEAR) & ev_eff;
  assign run  = run_q;
  assign trgo = ev_q;

  p_trgo_follows_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_raw |=> trgo);

  p_start_sets_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !cen_fall |=> run);

  p_cen_fall_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cen_fall |=> !run);

  p_gate_low_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_GATE) && !lvl_eff |-> !tick);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);

  logic [CNT_W-1:0] cnt_q, arr_sh;
  logic             upd_q, at_top, upd_ev;

  function automatic logic [CNT_W-1:0] step_val(logic [CNT_W-1:0] c, logic top);
    return top ? '0 : c + 1'b1;
  endfunction

  assign at_top = (cnt_q == arr_sh);
  assign upd_ev = clr | (tick & at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_ev;
      if (clr)       cnt_q <= '0;
      else if (tick) cnt_q <= step_val(cnt_q, at_top);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               arr_sh <= '0;
    else if (!run || upd_ev)  arr_sh <= arr;
  end

  assign cnt = cnt_q;
  assign upd = upd_q;

  p_upd_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> cnt == '0);

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr && (cnt != arr_sh) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && upd);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clr |=> $stable(cnt) && !upd);

  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && !clr && !tick |=> $stable(arr_sh));

endmodule

// File: rtl/tmr_slave_timer.sv
module tmr_slave_timer
  import tmr_slave_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_ITR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_lo,
  input  logic             mode_hi,
  input  logic [2:0]       tsel_lo,
  input  logic [1:0]       tsel_hi,
  input  logic             msync,
  input  logic             cen,
  input  logic [CNT_W-1:0] arr,
  input  logic [N_ITR-1:0] itr,
  input  logic             ti1,
  input  logic             ti1f,
  input  logic             ti2f,
  output logic [CNT_W-1:0] cnt,
  output logic             upd,
  output logic             trgo
);

  logic [MODE_W-1:0] mode_raw;
  logic [TSEL_W-1:0] tsel;
  logic              trg, sel_valid;
  smode_e            mode;
  logic              run, tick, clr;

  assign mode_raw = {mode_hi, mode_lo};
  assign tsel     = {tsel_hi, tsel_lo};
  assign mode     = mode_decode(mode_raw, sel_valid);

  tmr_trig_mux #(.N_ITR(N_ITR)) u_mux (
    .clk(clk), .rst_n(rst_n), .tsel(tsel), .itr(itr),
    .ti1(ti1), .ti1f(ti1f), .ti2f(ti2f),
    .trg(trg), .sel_valid(sel_valid)
  );

  tmr_slave_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .msync(msync), .cen(cen),
    .trg(trg), .run(run), .tick(tick), .clr(clr), .trgo(trgo)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .run(run),
    .arr(arr), .cnt(cnt), .upd(upd)
  );

  p_reserved_free_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_OFF) |-> (tick == run) && !clr);

endmodule

// File: tb/tmr_slave_timer_test.sv
module tmr_slave_timer_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode_lo = '0;
  logic         mode_hi = 1'b0;
  logic [2:0]   tsel_lo = '0;
  logic [1:0]   tsel_hi = '0;
  logic         msync = 1'b0;
  logic         cen = 1'b0;
  logic [W-1:0] arr = '0;
  logic [3:0]   itr = '0;
  logic         ti1 = 1'b0, ti1f = 1'b0, ti2f = 1'b0;
  logic [W-1:0] cnt;
  logic         upd, trgo;

  int    n_chk = 0, n_fail = 0;
  string phase = "R1";
  logic [31:0] lf = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  tmr_slave_timer #(.CNT_W(W), .N_ITR(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode_lo(mode_lo), .mode_hi(mode_hi),
    .tsel_lo(tsel_lo), .tsel_hi(tsel_hi), .msync(msync), .cen(cen),
    .arr(arr), .itr(itr), .ti1(ti1), .ti1f(ti1f), .ti2f(ti2f),
    .cnt(cnt), .upd(upd), .trgo(trgo)
  );

  // Behavioural reference model
  int m_cnt, m_upd, m_run, m_trgq, m_evq, m_arr, m_cenq, m_ti1q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_upd = 0; m_run = 0; m_trgq = 0;
      m_evq = 0; m_arr = 0; m_cenq = 0; m_ti1q = 0;
    end else begin
      int ts, md, trg, ev, eve, lvl, tk, cl, st, nrun, nct, uev;
      ts = int'({tsel_hi, tsel_lo});
      md = int'({mode_hi, mode_lo});
      if (ts < 4)       trg = int'(itr[ts]);
      else if (ts == 4) trg = int'(ti1) ^ m_ti1q;
      else if (ts == 5) trg = int'(ti1f);
      else if (ts == 6) trg = int'(ti2f);
      else              trg = 0;
      if (ts > 6 || md < 4 || md > 7) md = 0;
      ev  = (trg == 1 && m_trgq == 0) ? 1 : 0;
      eve = msync ? m_evq : ev;
      lvl = msync ? m_trgq : trg;
      if (md == 5)      tk = m_run & lvl;
      else if (md == 7) tk = m_run & eve;
      else              tk = m_run;
      cl = (md == 4) ? eve : 0;
      st = (md == 6) ? eve : 0;
      if (!cen && m_cenq == 1)                nrun = 0;
      else if ((cen && m_cenq == 0) || st==1) nrun = 1;
      else                                    nrun = m_run;
      nct = m_cnt; uev = 0;
      if (cl == 1) begin nct = 0; uev = 1; end
      else if (tk == 1) begin
        if (m_cnt == m_arr) begin nct = 0; uev = 1; end
        else nct = (m_cnt + 1) % (1 << W);
      end
      if (m_run == 0 || uev == 1) m_arr = int'(arr);
      m_cnt = nct; m_upd = uev; m_evq = ev; m_trgq = trg;
      m_run = nrun; m_cenq = int'(cen); m_ti1q = int'(ti1);
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("cnt", int'(cnt), m_cnt);
      chk("upd", int'(upd), m_upd);
      chk("trgo", int'(trgo), m_evq);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int m, int s);
    {mode_hi, mode_lo} = 4'(m);
    {tsel_hi, tsel_lo} = 5'(s);
  endtask

  task automatic lfsr_step();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
  endtask

  initial begin
    cyc(2);
    phase = "R1 reset";
    chk("cnt", int'(cnt), 0);
    chk("upd", int'(upd), 0);
    chk("trgo", int'(trgo), 0);
    rst_n = 1'b1;

    phase = "R2 R11 free run";
    set_mode(0, 0); arr = 8'd5; cyc(2);
    cen = 1'b1; cyc(2);
    chk("cnt after enable R11", int'(cnt), 1);
    cyc(20);
    cen = 1'b0; cyc(6);

    phase = "R10 shadow reload";
    arr = 8'd3; cyc(1); cen = 1'b1; cyc(2);
    arr = 8'd7; cyc(20); cen = 1'b0; cyc(2);

    phase = "R3 clear on edge";
    arr = 8'd50; set_mode(4, 0); cen = 1'b1; cyc(8);
    itr[0] = 1'b1; cyc(1);
    chk("cnt cleared R3", int'(cnt), 0);
    chk("upd R3", int'(upd), 1);
    cyc(3); itr[0] = 1'b0; cyc(5); itr[0] = 1'b1; cyc(4); itr[0] = 1'b0;
    cen = 1'b0; cyc(3); itr[0] = 1'b1; cyc(3); itr[0] = 1'b0; cyc(2);

    phase = "R4 gated";
    set_mode(5, 5); cen = 1'b1; cyc(4);
    ti1f = 1'b1; cyc(6); ti1f = 1'b0; cyc(6); ti1f = 1'b1; cyc(3); ti1f = 1'b0; cyc(2);
    cen = 1'b0; cyc(2);

    phase = "R5 start mode";
    set_mode(6, 6); cyc(4);
    ti2f = 1'b1; cyc(6); ti2f = 1'b0; cyc(3); ti2f = 1'b1; cyc(3);
    cen = 1'b1; cyc(2); cen = 1'b0; cyc(5); ti2f = 1'b0; cyc(2);

    phase = "R6 external step";
    arr = 8'd4; set_mode(7, 2); cen = 1'b1; cyc(2);
    for (int i = 0; i < 12; i++) begin itr[2] = ~itr[2]; cyc(1 + (i % 3)); end
    set_mode(7, 3);
    for (int i = 0; i < 8; i++) begin itr[3] = ~itr[3]; cyc(2); end

    phase = "R12 ti1 change pulse";
    set_mode(7, 4);
    for (int i = 0; i < 10; i++) begin ti1 = ~ti1; cyc(1 + (i % 2) * 2); end

    phase = "R9 delayed reaction";
    msync = 1'b1; arr = 8'd60; set_mode(4, 1); cyc(6);
    itr[1] = 1'b1; cyc(1);
    chk("trgo R9", int'(trgo), 1);
    cyc(1);
    chk("cnt cleared late R9", int'(cnt), 0);
    cyc(3); itr[1] = 1'b0;
    set_mode(5, 1); cyc(3); itr[1] = 1'b1; cyc(4); itr[1] = 1'b0; cyc(3);
    msync = 1'b0;

    phase = "R8 reserved codes";
    set_mode(2, 0); itr[0] = 1'b1; cyc(3); itr[0] = 1'b0; cyc(3);
    set_mode(4, 7); cyc(5); set_mode(13, 0); cyc(5);
    set_mode(5, 9); cyc(4);

    phase = "R7 mixed selection";
    for (int i = 0; i < 3000; i++) begin
      lfsr_step();
      itr  = lf[3:0];
      ti1  = lf[4]; ti1f = lf[5]; ti2f = lf[6];
      if (lf[12:7] == 6'd0) msync = ~msync;
      if (lf[17:13] < 5'd3) cen = ~cen;
      if (lf[22:18] == 5'd0) set_mode(int'(lf[26:23]), int'(lf[30:27]) % 8);
      if (lf[31] && lf[11:8] == 4'hF) arr = lf[7:0] % 8'd20;
      cyc(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule